// File: doc/BRIEF.md
# Serial Clock-Chip Time Reader

This block reads the current time from an external real-time clock chip over a four-wire serial bus and presents it in binary. A single-cycle `start` pulse begins a read. The block raises chip enable and waits a settle interval. It then clocks out a one-byte register address of zero and clocks in seven bytes in a single burst. The chip holds its fields in BCD. The block masks each field, converts it to binary, and folds either hour format into a value from 0 to 23.

After the last byte the block lowers chip enable and waits the settle interval again. It then updates all time outputs at once and pulses `done` for one cycle. The outputs keep those values until the next `done`. The serial clock rate and the settle interval both come from a divider parameter, so the same block fits slow chips on a fast system clock.

Top module: `rtc_time_fetch`

## Requirements
- R1: While `rst` is high and after it is released, all time outputs read zero and `spi_ce`, `spi_sck`, `spi_mosi` and `done` are low until the first read completes.
- R2: A `start` while idle raises `spi_ce` at the next clock edge. The first `spi_sck` rise follows SETTLE*DIV clock cycles later. Exactly 64 `spi_sck` pulses occur before `spi_ce` falls, and `done` rises SETTLE*DIV clock cycles after `spi_ce` falls.
- R3: `spi_sck` is low whenever `spi_ce` is low. Each pulse stays high for DIV cycles and low for DIV cycles. During the first 8 pulses `spi_mosi` carries the address 0x00, most significant bit first.
- R4: `spi_miso` is sampled at the end of each high half of pulses 9 to 64, most significant bit first. The seven bytes are, in arrival order: seconds, minutes, hours, day-of-week, date, month, year.
- R5: Seconds and minutes are masked with 0x7F, date with 0x3F and month with 0x1F, and then converted from BCD to binary (upper nibble times ten plus lower nibble).
- R6: `out_wday` equals the BCD value of (day-of-week byte AND 0x07) minus one, taken modulo 8.
- R7: When hour byte bit 6 is 0, `out_hour` is the BCD value of bits 5:0.
- R8: When hour byte bit 6 is 1, bits 4:0 hold a BCD hour h from 1 to 12 and bit 5 set means PM. In that case `out_hour` is 0 for 12 AM, h for 1–11 AM, 12 for 12 PM and h+12 for 1–11 PM.
- R9: `out_year` equals 2000 plus the BCD value of the year byte.
- R10: A `start` while a read is in progress has no effect. Each accepted start yields exactly one `spi_ce` assertion and one `done` pulse.
- R11: `done` lasts one cycle, and every time output holds its value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one time read |
| spi_ce | output | 1 | Chip enable, active high |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the chip |
| spi_miso | input | 1 | Serial data from the chip |
| out_sec | output | 7 | Seconds, binary |
| out_min | output | 7 | Minutes, binary |
| out_hour | output | 6 | Hour 0–23, binary |
| out_wday | output | 3 | Weekday 0–6 |
| out_mday | output | 6 | Day of month, binary |
| out_month | output | 5 | Month, binary |
| out_year | output | 12 | Full year |
| done | output | 1 | One-cycle strobe: outputs updated |

## Verification
The properties assume that `rst` is held high from time zero and that `start` is a synchronous one-cycle pulse. They also assume that the chip changes `spi_miso` only while `spi_sck` is high and well before the end of the high half.

The stimulus meets these assumptions. Its chip model drives each data bit on the rising serial clock, DIV cycles before the block samples it, and all pulses are driven at the falling system clock edge. Every byte the stimulus supplies is valid BCD once masked, so the field ranges the bench checks are well defined. The byte with stray high bits is the one exception, and it exists to exercise the masks.

// File: rtl/rtc_time_fetch.sv
module rtc_time_fetch #(
  parameter int DIV       = 4,
  parameter int SETTLE    = 3,
  parameter int YEAR_BASE = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        spi_ce,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [6:0]  out_sec,
  output logic [6:0]  out_min,
  output logic [5:0]  out_hour,
  output logic [2:0]  out_wday,
  output logic [5:0]  out_mday,
  output logic [4:0]  out_month,
  output logic [11:0] out_year,
  output logic        done
);

  localparam int NBYTES = 7;
  localparam int NBITS  = 8 * (NBYTES + 1);
  localparam int BW     = $clog2(NBITS);
  localparam int CW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SW     = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [7:0] RD_ADDR = 8'h00;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_XFER, S_POST} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [SW-1:0]        scnt;
  logic [BW-1:0]        bitn;
  logic [8*NBYTES-1:0]  rx;

  wire tick        = (cnt == CW'(DIV - 1));
  wire settle_last = (scnt == SW'(SETTLE - 1));

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
  endfunction

  wire [7:0] b_sec  = rx[55:48];
  wire [7:0] b_min  = rx[47:40];
  wire [7:0] b_hour = rx[39:32];
  wire [7:0] b_dow  = rx[31:24];
  wire [7:0] b_date = rx[23:16];
  wire [7:0] b_mon  = rx[15:8];
  wire [7:0] b_year = rx[7:0];

  wire [7:0] c_sec  = bcd2bin(b_sec & 8'h7F);
  wire [7:0] c_min  = bcd2bin(b_min & 8'h7F);
  wire [7:0] c_date = bcd2bin(b_date & 8'h3F);
  wire [7:0] c_mon  = bcd2bin(b_mon & 8'h1F);
  wire [7:0] c_year = bcd2bin(b_year);
  wire [2:0] c_wday = b_dow[2:0] - 3'd1;

  wire [7:0] h12    = bcd2bin({3'd0, b_hour[4:0]});
  wire [7:0] h12z   = (h12 == 8'd12) ? 8'd0 : h12;
  wire [7:0] h12o   = h12z + (b_hour[5] ? 8'd12 : 8'd0);
  wire [7:0] h24    = bcd2bin({2'd0, b_hour[5:0]});
  wire [7:0] c_hour = b_hour[6] ? h12o : h24;

  assign spi_mosi = (st == S_XFER && bitn < BW'(8)) ? RD_ADDR[3'd7 - bitn[2:0]] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      scnt      <= '0;
      bitn      <= '0;
      rx        <= '0;
      spi_ce    <= 1'b0;
      spi_sck   <= 1'b0;
      done      <= 1'b0;
      out_sec   <= '0;
      out_min   <= '0;
      out_hour  <= '0;
      out_wday  <= '0;
      out_mday  <= '0;
      out_month <= '0;
      out_year  <= '0;
    end else begin
      done <= 1'b0;
      cnt  <= (st == S_IDLE || tick) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE:
          if (start) begin
            st     <= S_PRE;
            spi_ce <= 1'b1;
            scnt   <= '0;
          end
        S_PRE:
          if (tick) begin
            if (settle_last) begin
              st      <= S_XFER;
              spi_sck <= 1'b1;
              bitn    <= '0;
              scnt    <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        S_XFER:
          if (tick) begin
            if (spi_sck) begin
              spi_sck <= 1'b0;
              if (bitn >= BW'(8)) rx <= {rx[8*NBYTES-2:0], spi_miso};
            end else if (bitn == BW'(NBITS - 1)) begin
              st     <= S_POST;
              spi_ce <= 1'b0;
            end else begin
              bitn    <= bitn + 1'b1;
              spi_sck <= 1'b1;
            end
          end
        S_POST:
          if (tick) begin
            if (settle_last) begin
              st        <= S_IDLE;
              done      <= 1'b1;
              out_sec   <= c_sec[6:0];
              out_min   <= c_min[6:0];
              out_hour  <= c_hour[5:0];
              out_wday  <= c_wday;
              out_mday  <= c_date[5:0];
              out_month <= c_mon[4:0];
              out_year  <= 12'(YEAR_BASE) + {4'd0, c_year};
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rtc_time_fetch_chk.sv
module rtc_time_fetch_chk #(
  parameter int DIV = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        spi_ce,
  input logic        spi_sck,
  input logic        done,
  input logic [6:0]  out_sec,
  input logic [6:0]  out_min,
  input logic [5:0]  out_hour,
  input logic [2:0]  out_wday,
  input logic [5:0]  out_mday,
  input logic [4:0]  out_month,
  input logic [11:0] out_year
);

  logic [15:0] hi_cnt;
  logic [15:0] rises;
  logic        sck_q, ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      rises  <= '0;
      sck_q  <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      sck_q  <= spi_sck;
      ce_q   <= spi_ce;
      hi_cnt <= spi_sck ? hi_cnt + 1'b1 : '0;
      if (spi_ce && !ce_q) rises <= '0;
      else if (spi_sck && !sck_q) rises <= rises + 1'b1;
    end
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !spi_ce |-> !spi_sck);

  assert_sck_high_len_R3: assert property (@(posedge clk) disable iff (rst)
    (!spi_sck && sck_q) |-> (hi_cnt == 16'(DIV)));

  assert_pulse_count_R2: assert property (@(posedge clk) disable iff (rst)
    (!spi_ce && ce_q) |-> (rises == 16'd64));

  assert_done_after_ce_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !spi_ce);

  assert_ce_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
    (spi_ce && !ce_q) |-> $past(start));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_sec) && $stable(out_min) && $stable(out_hour) &&
               $stable(out_wday) && $stable(out_mday) && $stable(out_month) &&
               $stable(out_year)));

endmodule

bind rtc_time_fetch rtc_time_fetch_chk #(.DIV(DIV)) i_chk (
  .clk(clk), .rst(rst), .start(start), .spi_ce(spi_ce), .spi_sck(spi_sck),
  .done(done), .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour),
  .out_wday(out_wday), .out_mday(out_mday), .out_month(out_month),
  .out_year(out_year)
);

// File: tb/test_rtc_time_fetch.sv
module test_rtc_time_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int SETTLE     = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic spi_ce, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [6:0]  out_sec, out_min;
  logic [5:0]  out_hour, out_mday;
  logic [2:0]  out_wday;
  logic [4:0]  out_month;
  logic [11:0] out_year;
  logic done;

  rtc_time_fetch #(.DIV(DIV), .SETTLE(SETTLE), .YEAR_BASE(2000)) i_rtc_time_fetch (
    .clk(clk), .rst(rst), .start(start), .spi_ce(spi_ce), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .out_sec(out_sec), .out_min(out_min),
    .out_hour(out_hour), .out_wday(out_wday), .out_mday(out_mday),
    .out_month(out_month), .out_year(out_year), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int sec; int min; int hour; int wday; int mday; int mon; int year;
    string htag;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int n_tests = 0, n_fail = 0;
  int n_reads = 0, ce_rises = 0;
  int rise_k = 0;
  logic [55:0] frame = '0;
  logic [7:0]  addr_seen = 8'hFF;
  time t_hi = 0;
  int bad_hi = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // chip model: next data bit presented on each rising serial clock
  always @(posedge spi_sck) begin
    t_hi = $time;
    if (rise_k >= 8) spi_miso <= frame[55 - (rise_k - 8)];
    rise_k = rise_k + 1;
  end

  always @(negedge spi_sck) begin
    if ($time - t_hi != DIV * CLK_PERIOD) bad_hi++;
    if (rise_k <= 8) addr_seen = {addr_seen[6:0], spi_mosi};
  end

  always @(posedge spi_ce) ce_rises++;

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        last_exp = e;
        check("R4/R5 seconds", int'(out_sec), e.sec);
        check("R4/R5 minutes", int'(out_min), e.min);
        check(e.htag, int'(out_hour), e.hour);
        check("R6 weekday", int'(out_wday), e.wday);
        check("R5 date", int'(out_mday), e.mday);
        check("R5 month", int'(out_month), e.mon);
        check("R9 year", int'(out_year), e.year);
      end
    end
  end

  task automatic read_time(input logic [7:0] bs, bm, bh, bd, bdt, bmo, by,
                           input bit poke);
    exp_t e;
    int v;
    time t0, t1;
    frame = {bs, bm, bh, bd, bdt, bmo, by};
    rise_k = 0;
    addr_seen = 8'hFF;
    e.sec  = b2i(bs & 8'h7F);
    e.min  = b2i(bm & 8'h7F);
    e.mday = b2i(bdt & 8'h3F);
    e.mon  = b2i(bmo & 8'h1F);
    e.year = 2000 + b2i(by);
    e.wday = (b2i({5'd0, bd[2:0]}) - 1) & 7;
    if (bh[6]) begin
      v = b2i({3'd0, bh[4:0]});
      if (bh[5]) e.hour = (v == 12) ? 12 : v + 12;
      else       e.hour = (v == 12) ? 0 : v;
      e.htag = "R8 hour 12h";
    end else begin
      e.hour = b2i({2'd0, bh[5:0]});
      e.htag = "R7 hour 24h";
    end
    q.push_back(e);
    n_reads++;
    @(negedge clk) start = 1'b1;
    @(posedge spi_ce) t0 = $time;
    @(negedge clk) start = 1'b0;
    @(posedge spi_sck);
    check("R2 ce-to-sck", int'($time - t0), SETTLE * DIV * CLK_PERIOD);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    @(negedge spi_ce) t1 = $time;
    check("R2 pulse count", rise_k, 64);
    check("R3 address", int'(addr_seen), 0);
    @(posedge done);
    check("R2 ce-to-done", int'($time - t1), SETTLE * DIV * CLK_PERIOD);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ce", int'(spi_ce), 0);
    check("R1 sck", int'(spi_sck), 0);
    check("R1 done", int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mosi", int'(spi_mosi), 0);
    check("R1 year", int'(out_year), 0);
    check("R1 hour", int'(out_hour), 0);

    read_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b0);
    read_time(8'h00, 8'h00, 8'h52, 8'h01, 8'h01, 8'h01, 8'h00, 1'b0);
    read_time(8'h10, 8'h20, 8'h72, 8'h02, 8'h10, 8'h02, 8'h05, 1'b0);
    read_time(8'h59, 8'h01, 8'h71, 8'h05, 8'h28, 8'h11, 8'h50, 1'b0);
    read_time(8'h07, 8'h08, 8'h47, 8'h06, 8'h09, 8'h10, 8'h11, 1'b0);
    read_time(8'h33, 8'h44, 8'h61, 8'h04, 8'h19, 8'h07, 8'h23, 1'b0);
    read_time(8'hC5, 8'hA7, 8'h89, 8'hFC, 8'hE8, 8'hE9, 8'h42, 1'b0);
    read_time(8'h30, 8'h15, 8'h00, 8'h03, 8'h15, 8'h06, 8'h24, 1'b1);

    repeat (200) @(negedge clk);
    check("R11 hold sec", int'(out_sec), last_exp.sec);
    check("R11 hold hour", int'(out_hour), last_exp.hour);
    check("R11 hold year", int'(out_year), last_exp.year);
    check("R10 ce assertions", ce_rises, n_reads);
    check("R10 pending results", q.size(), 0);
    check("R3 high half length", bad_hi, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule